// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block is the bus-facing end of a small processor-style master. It takes one transfer request at a time and runs it over a shared 16-bit set of pins as a four-phase cycle, T1 to T4. In T1 the pins carry the address while a latch strobe pulses, so that external logic can hold the address. In T2 to T4 the pins carry write data on a write. On a read the pins are left floating and the value on them is taken at the end of T3. Each pin is modelled as a separate output value and a per-lane output enable, one enable per 8-bit lane.

A write leaves any lane whose byte enable is clear floating for T2 to T4. An address-disable input stops the address from being driven in T1, but the strobe still pulses. Reads that the master serves from its own internal memory can be echoed onto the pins in T3 and T4 when show-read is on. Show-read is turned on by a live control input or by a strap bit captured at reset. While reset is active, and while a bus-hold request is granted, every lane floats. The value on the pins is kept as a configuration word when reset is released.

Requests use a valid/ready handshake. `req_ready` is high only when the sequencer is idle and no hold is requested, so the master keeps `req_valid` and its fields steady until it sees ready. The response is a single-cycle `rsp_valid` pulse with no back-pressure, and the master must take `rsp_rdata` in that cycle.

Top module: `adbus_seq`

## Requirements
- R1: `req_ready` is high only in idle with `hold_req` low. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high, and T1 is the next cycle.
- R2: `ale` is high for exactly the T1 cycle. In T1, with `addr_dis` low, both lanes are enabled and `bus_out` equals the request address. `ale` is low in T2 to T4.
- R3: On a write, `bus_out` equals the write data in T2, T3 and T4. Lane enable `bus_oe[i]` follows `req_be[i]`, where bit 0 is the low lane (pins 7:0) and bit 1 is the high lane (pins 15:8).
- R4: On a read without echo, no lane is enabled in T2 to T4. `rsp_rdata` returns `bus_in` as sampled on the clock edge that ends T3. Later changes to `bus_in` have no effect on it.
- R5: `rsp_valid` is high for exactly one cycle, the cycle right after T4, and it is low in T4.
- R6: While `addr_dis` is high in T1, no lane is enabled, but `ale` still pulses.
- R7: On an internal read (`req_internal`=1) with show-read on, both lanes drive `req_int_rdata` in T3 and T4 and float in T2. Without show-read the lanes float. In both cases `rsp_rdata` returns the internal data. External reads never echo.
- R8: Show-read is on when `show_rd_cfg` is high, or when bit 0 of the captured configuration word is 0.
- R9: `hold_req` is acted on only in idle, and that includes the idle cycle after a cycle's T4. `hold_ack` rises the next cycle. During a hold all lanes float, `ale` stays low, requests are refused, and idle returns one cycle after `hold_req` falls.
- R10: While `rst_n` is low, `bus_oe` is 0 and `ale`, `hold_ack` and `rsp_valid` are low.
- R11: `cfg_word` holds the `bus_in` value from the last clock edge before `rst_n` rises. It stays unchanged after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 16 | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables, bit 0 = low lane |
| req_wdata | input | 16 | Write data |
| req_internal | input | 1 | Read is served from internal memory |
| req_int_rdata | input | 16 | Internal memory read data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_valid |
| addr_dis | input | 1 | Suppress address drive in T1 |
| show_rd_cfg | input | 1 | Show-read enable control |
| hold_req | input | 1 | Bus hold request |
| hold_ack | output | 1 | Bus hold granted, pins floating |
| ale | output | 1 | Address latch strobe |
| bus_oe | output | 2 | Per-lane output enable |
| bus_out | output | 16 | Pin output value |
| bus_in | input | 16 | Pin input value |
| cfg_word | output | 16 | Configuration word captured at reset release |

## Verification
The assertions check the rules that hold on every cycle. They cover the one-cycle `ale` and `rsp_valid` pulses, the fixed four-cycle gap from strobe to completion, and floating pins during hold and reset. They also check that an accepted request always leads to T1, and that no address is driven while `addr_dis` is high. What the pins carry in each phase needs the bench's scenarios. That covers the values on the pins, the lane enables from the byte enables, and the exact edge where read data is sampled. It also covers the two ways of enabling show-read, the configuration word kept across reset release, and a hold that waits out a cycle already in flight.

// File: rtl/adbus_pkg.sv
package adbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_T4   = 3'd4,
    PH_HOLD = 3'd5
  } phase_e;
endpackage

// File: rtl/adbus_phase_fsm.sv
module adbus_phase_fsm
  import adbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   hold_req,
  output logic   req_ready,
  output phase_e phase,
  output logic   cap_en,
  output logic   done,
  output logic   hold_ack
);
  phase_e nxt;

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE: begin
        if (hold_req)       nxt = PH_HOLD;
        else if (req_valid) nxt = PH_T1;
      end
      PH_T1:   nxt = PH_T2;
      PH_T2:   nxt = PH_T3;
      PH_T3:   nxt = PH_T4;
      PH_T4:   nxt = PH_IDLE;
      PH_HOLD: if (!hold_req) nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      done  <= 1'b0;
    end else begin
      phase <= nxt;
      done  <= (phase == PH_T4);
    end
  end

  assign req_ready = (phase == PH_IDLE) && !hold_req;
  assign cap_en    = (phase == PH_T3);
  assign hold_ack  = (phase == PH_HOLD);
endmodule

// File: rtl/adbus_lane_drv.sv
module adbus_lane_drv
  import adbus_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  phase_e             phase,
  input  logic               addr_dis,
  input  logic               show_en,
  input  logic               wr,
  input  logic               intl,
  input  logic               be,
  input  logic [LANE_W-1:0]  addr_byte,
  input  logic [LANE_W-1:0]  wdata_byte,
  input  logic [LANE_W-1:0]  idata_byte,
  output logic               oe,
  output logic [LANE_W-1:0]  dout
);
  always_comb begin
    oe   = 1'b0;
    dout = '0;
    unique case (phase)
      PH_T1: begin
        oe   = !addr_dis;
        dout = addr_byte;
      end
      PH_T2: begin
        if (wr) begin
          oe   = be;
          dout = wdata_byte;
        end
      end
      PH_T3, PH_T4: begin
        if (wr) begin
          oe   = be;
          dout = wdata_byte;
        end else if (intl && show_en) begin
          oe   = 1'b1;
          dout = idata_byte;
        end
      end
      default: begin
        oe   = 1'b0;
        dout = '0;
      end
    endcase
  end
endmodule

// File: rtl/adbus_cfg_cap.sv
module adbus_cfg_cap #(
  parameter int BUS_W     = 16,
  parameter int STRAP_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] bus_in,
  input  logic             show_rd_cfg,
  output logic [BUS_W-1:0] cfg_word,
  output logic             show_en
);
  logic [BUS_W-1:0] cfg_q;

  // Samples the pins on every edge while reset is held, so the last
  // sample before release is what remains.
  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= bus_in;
  end

  assign cfg_word = cfg_q;
  assign show_en  = show_rd_cfg || !cfg_q[STRAP_BIT];
endmodule

// File: rtl/adbus_seq.sv
module adbus_seq
  import adbus_pkg::*;
#(
  parameter int BUS_W     = 16,
  parameter int LANE_W    = 8,
  parameter int STRAP_BIT = 0,
  localparam int LANES    = BUS_W / LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [BUS_W-1:0] req_addr,
  input  logic             req_write,
  input  logic [LANES-1:0] req_be,
  input  logic [BUS_W-1:0] req_wdata,
  input  logic             req_internal,
  input  logic [BUS_W-1:0] req_int_rdata,
  output logic             rsp_valid,
  output logic [BUS_W-1:0] rsp_rdata,
  input  logic             addr_dis,
  input  logic             show_rd_cfg,
  input  logic             hold_req,
  output logic             hold_ack,
  output logic             ale,
  output logic [LANES-1:0] bus_oe,
  output logic [BUS_W-1:0] bus_out,
  input  logic [BUS_W-1:0] bus_in,
  output logic [BUS_W-1:0] cfg_word
);
  phase_e           phase;
  logic             cap_en;
  logic             show_en;
  logic             accept;
  logic [BUS_W-1:0] addr_q, wdata_q, idata_q, rdata_q;
  logic [LANES-1:0] be_q;
  logic             wr_q, intl_q;

  adbus_phase_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .hold_req  (hold_req),
    .req_ready (req_ready),
    .phase     (phase),
    .cap_en    (cap_en),
    .done      (rsp_valid),
    .hold_ack  (hold_ack)
  );

  adbus_cfg_cap #(.BUS_W(BUS_W), .STRAP_BIT(STRAP_BIT)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_in      (bus_in),
    .show_rd_cfg (show_rd_cfg),
    .cfg_word    (cfg_word),
    .show_en     (show_en)
  );

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      idata_q <= '0;
      be_q    <= '0;
      wr_q    <= 1'b0;
      intl_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        idata_q <= req_int_rdata;
        be_q    <= req_be;
        wr_q    <= req_write;
        intl_q  <= req_internal;
      end
      if (cap_en && !wr_q) rdata_q <= intl_q ? idata_q : bus_in;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    adbus_lane_drv #(.LANE_W(LANE_W)) u_lane (
      .phase      (phase),
      .addr_dis   (addr_dis),
      .show_en    (show_en),
      .wr         (wr_q),
      .intl       (intl_q),
      .be         (be_q[g]),
      .addr_byte  (addr_q[g*LANE_W +: LANE_W]),
      .wdata_byte (wdata_q[g*LANE_W +: LANE_W]),
      .idata_byte (idata_q[g*LANE_W +: LANE_W]),
      .oe         (bus_oe[g]),
      .dout       (bus_out[g*LANE_W +: LANE_W])
    );
  end

  assign ale       = (phase == PH_T1);
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/adbus_seq_chk.sv
module adbus_seq_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             addr_dis,
  input logic             hold_ack,
  input logic             rsp_valid,
  input logic             ale,
  input logic [LANES-1:0] bus_oe
);
  AST_ACCEPT_TO_T1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> ale);                                   // R1
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ale && bus_oe == '0));                             // R1
  AST_ALE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);                                                     // R2
  AST_ADDR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ale && !addr_dis |-> bus_oe == '1);                                // R2
  AST_DONE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(ale, 4));                                      // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);                                         // R5
  AST_ADDR_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    ale && addr_dis |-> bus_oe == '0);                                 // R6
  AST_HOLD_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> (bus_oe == '0 && !ale && !req_ready));                // R9
  AST_RESET_FLOAT: assert property (@(posedge clk)
    !rst_n && !$past(rst_n) |-> (bus_oe == '0 && !ale && !hold_ack && !rsp_valid)); // R10
endmodule

bind adbus_seq adbus_seq_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .addr_dis  (addr_dis),
  .hold_ack  (hold_ack),
  .rsp_valid (rsp_valid),
  .ale       (ale),
  .bus_oe    (bus_oe)
);

// File: tb/adbus_seq_tb_top.sv
module adbus_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [15:0] req_addr = '0, req_wdata = '0, req_int_rdata = '0;
  logic        req_write = 1'b0, req_internal = 1'b0;
  logic [1:0]  req_be = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        addr_dis = 1'b0, show_rd_cfg = 1'b0, hold_req = 1'b0;
  logic        hold_ack, ale;
  logic [1:0]  bus_oe;
  logic [15:0] bus_out, bus_in = '0, cfg_word;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  adbus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_be(req_be),
    .req_wdata(req_wdata), .req_internal(req_internal),
    .req_int_rdata(req_int_rdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .addr_dis(addr_dis), .show_rd_cfg(show_rd_cfg), .hold_req(hold_req),
    .hold_ack(hold_ack), .ale(ale), .bus_oe(bus_oe), .bus_out(bus_out),
    .bus_in(bus_in), .cfg_word(cfg_word)
  );

  task automatic chk(input string msg, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", msg, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Reset with a pattern on the pins; checks R10 during and R11 after.
  task automatic do_reset(input logic [15:0] pat);
    @(negedge clk);
    rst_n  = 1'b0;
    bus_in = pat;
    repeat (3) @(negedge clk);
    chk("R10 oe in reset", {14'd0, bus_oe}, 16'd0);
    chk("R10 ale/hold/done in reset", {13'd0, ale, hold_ack, rsp_valid}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    bus_in = ~pat;
    @(negedge clk);
    chk("R11 cfg word kept", cfg_word, pat);
    chk("R1 ready after reset", {15'd0, req_ready}, 16'd1);
  endtask

  // One full cycle with expected enables for T1, T2, T3/T4.
  task automatic run_cyc(input string tg, input logic [15:0] a, input logic wr,
                         input logic [1:0] be, input logic [15:0] wd, input logic intl,
                         input logic [15:0] idat, input logic [15:0] ext,
                         input logic [1:0] e1, input logic [1:0] e2, input logic [1:0] e34,
                         input logic [15:0] eout, input logic [15:0] erd);
    bus_in        = ext ^ 16'h0F0F;
    req_addr      = a;
    req_write     = wr;
    req_be        = be;
    req_wdata     = wd;
    req_internal  = intl;
    req_int_rdata = idat;
    req_valid     = 1'b1;
    chk("R1 ready before accept", {15'd0, req_ready}, 16'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 ale in T1", {15'd0, ale}, 16'd1);
    chk({tg, " T1 enables"}, {14'd0, bus_oe}, {14'd0, e1});
    if (e1 != 2'b00) chk("R2 address in T1", bus_out, a);
    @(negedge clk);
    chk("R2 ale low in T2", {15'd0, ale}, 16'd0);
    chk({tg, " T2 enables"}, {14'd0, bus_oe}, {14'd0, e2});
    bus_in = ext;
    for (int p = 3; p <= 4; p++) begin
      @(negedge clk);
      chk({tg, " T3/T4 enables"}, {14'd0, bus_oe}, {14'd0, e34});
      if (e34 != 2'b00) chk({tg, " T3/T4 pin data"}, bus_out, eout);
      if (p == 4) begin
        chk("R5 no done in T4", {15'd0, rsp_valid}, 16'd0);
        bus_in = ~ext;
      end
    end
    @(negedge clk);
    chk("R5 done after T4", {15'd0, rsp_valid}, 16'd1);
    if (!wr) chk({tg, " read data"}, rsp_rdata, erd);
    @(negedge clk);
    chk("R5 done one cycle", {15'd0, rsp_valid}, 16'd0);
  endtask

  task automatic t_write();
    run_cyc("R3 full", 16'h1234, 1'b1, 2'b11, 16'hBEEF, 1'b0, 16'h0, 16'h0,
            2'b11, 2'b11, 2'b11, 16'hBEEF, 16'h0);
    run_cyc("R3 low lane", 16'h2002, 1'b1, 2'b01, 16'h55AA, 1'b0, 16'h0, 16'h0,
            2'b11, 2'b01, 2'b01, 16'h55AA, 16'h0);
    run_cyc("R3 high lane", 16'h3003, 1'b1, 2'b10, 16'hC001, 1'b0, 16'h0, 16'h0,
            2'b11, 2'b10, 2'b10, 16'hC001, 16'h0);
  endtask

  task automatic t_read();
    run_cyc("R4 ext read", 16'h4444, 1'b0, 2'b11, 16'h0, 1'b0, 16'h0, 16'hC3A5,
            2'b11, 2'b00, 2'b00, 16'h0, 16'hC3A5);
  endtask

  task automatic t_addr_dis();
    addr_dis = 1'b1;
    run_cyc("R6 suppressed", 16'h5555, 1'b1, 2'b11, 16'h0F0F, 1'b0, 16'h0, 16'h0,
            2'b00, 2'b11, 2'b11, 16'h0F0F, 16'h0);
    addr_dis = 1'b0;
  endtask

  task automatic t_show_cfg();
    show_rd_cfg = 1'b1;
    run_cyc("R7 R8 echo by control", 16'h6006, 1'b0, 2'b11, 16'h0, 1'b1, 16'h7E81,
            16'h1111, 2'b11, 2'b00, 2'b11, 16'h7E81, 16'h7E81);
    run_cyc("R7 external no echo", 16'h6106, 1'b0, 2'b11, 16'h0, 1'b0, 16'h7E81,
            16'h2468, 2'b11, 2'b00, 2'b00, 16'h0, 16'h2468);
    show_rd_cfg = 1'b0;
    run_cyc("R7 echo off", 16'h6206, 1'b0, 2'b11, 16'h0, 1'b1, 16'h9A3C,
            16'h1111, 2'b11, 2'b00, 2'b00, 16'h0, 16'h9A3C);
  endtask

  task automatic t_strap();
    do_reset(16'hA5C2);
    run_cyc("R8 echo by strap", 16'h7007, 1'b0, 2'b11, 16'h0, 1'b1, 16'h3CC3,
            16'h1111, 2'b11, 2'b00, 2'b11, 16'h3CC3, 16'h3CC3);
  endtask

  task automatic t_hold_idle();
    hold_req = 1'b1;
    #1;
    chk("R9 ready drops on hold", {15'd0, req_ready}, 16'd0);
    @(negedge clk);
    chk("R9 hold granted", {15'd0, hold_ack}, 16'd1);
    chk("R9 float in hold", {14'd0, bus_oe}, 16'd0);
    req_valid = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 request refused in hold", {14'd0, ale, req_ready}, 16'd0);
    req_valid = 1'b0;
    hold_req  = 1'b0;
    @(negedge clk);
    chk("R9 hold released", {14'd0, hold_ack, req_ready}, 16'd1);
  endtask

  task automatic t_hold_mid();
    req_addr  = 16'h8888;
    req_write = 1'b1;
    req_be    = 2'b11;
    req_wdata = 16'h1357;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    hold_req  = 1'b1;
    for (int p = 2; p <= 4; p++) begin
      @(negedge clk);
      chk("R9 no hold mid-cycle", {15'd0, hold_ack}, 16'd0);
      chk("R9 data kept mid-cycle", bus_out, 16'h1357);
    end
    @(negedge clk);
    chk("R9 done before hold", {14'd0, rsp_valid, hold_ack}, 16'd2);
    @(negedge clk);
    chk("R9 hold after cycle", {15'd0, hold_ack}, 16'd1);
    hold_req = 1'b0;
    @(negedge clk);
    chk("R9 idle after mid hold", {15'd0, hold_ack}, 16'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset(16'h5A31);
    t_write();
    t_read();
    t_addr_dis();
    t_show_cfg();
    t_hold_idle();
    t_hold_mid();
    t_strap();
    finish_run();
  end
endmodule